// File: doc/BRIEF.md
# SPI Paged Register Access Slave

This block lets an external SPI host reach an 11-bit register space inside the chip. The host transfers bytes only. Each access is framed by chip select. The first byte of an access is a command byte: its top bit gives the direction and its low seven bits give the offset within a page. The upper four address bits come from a local page register that the block holds itself. Every byte after the command byte is a data byte. The block moves each data byte to or from a plain internal register-file port, which has an address, write data, a write strobe, a read strobe and read data.

The offset after the command byte advances by one for each data byte, so the host can stream several registers in one access. The page register sits at the same in-page offset on every page. A host can therefore change pages whatever page is currently selected. The block handles the page register itself, and accesses to it never reach the register-file port. The register file answers a read strobe with data one clock cycle later.

Top module: `spi_paged_regif`

## Requirements
- R1: After reset the page value is 0, `spi_miso` is low, and `reg_we` and `reg_re` are low.
- R2: In the command byte, bit 7 = 1 selects a write access and bit 7 = 0 selects a read access. Bits [6:0] give the low address. Every register-port address is {page[3:0], low[6:0]}.
- R3: In a write access, each data byte not aimed at the page offset produces exactly one cycle of `reg_we`. In that cycle `reg_addr` holds the current address and `reg_wdata` holds the byte.
- R4: Each data byte advances the low address by one, modulo 128. The page does not change, except through a write to the page offset.
- R5: In a read access, the first data byte shifted out is the register at the commanded address, and later bytes come from the following addresses. The block issues one-cycle `reg_re` pulses and takes `reg_rdata` one cycle after each pulse. `spi_miso` sends zero during the command byte and during all bytes of a write access.
- R6: Low address 0x7C is the page register on every page. A command byte of 0xFC writes it and 0x7C reads it. A write loads data bits [3:0]. A read returns {4'b0000, page}. Neither kind of access produces `reg_we` or `reg_re`.
- R7: Raising chip select in the middle of a byte discards that byte without a register write. The next selected byte is treated as a command byte.
- R8: SPI mode 0, MSB first. MOSI is sampled on rising SCLK and MISO changes after falling SCLK. Each SCLK phase must last at least 6 system clock cycles.
- R9: `reg_we` and `reg_re` are never high in the same cycle. Neither is raised while chip select has been high for the previous four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock (idle low) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host (low when idle) |
| reg_addr | output | 11 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Register-file write strobe, one cycle |
| reg_re | output | 1 | Register-file read strobe, one cycle |
| reg_rdata | input | 8 | Register-file read data, valid the cycle after `reg_re` |

## Verification
The checker watches the register-port strobes on every cycle. It checks that the two strobes are exclusive and last a single cycle, that the page offset never appears on the port, and that the port stays silent while chip select is idle. What the host sees can only be shown by the bench's scenarios: the byte values returned on MISO, the order of addresses in bursts and their wrap at the end of a page, and a page change in the middle of a burst that moves the following writes. The bench also shows that an aborted byte leaves the target register unchanged.

// File: rtl/spi_paged_pkg.sv
package spi_paged_pkg;

    localparam int unsigned PKG_ADDR_W = 11;
    localparam int unsigned PKG_LOW_W  = 7;
    localparam int unsigned PKG_DATA_W = 8;
    localparam int unsigned PKG_SYNC   = 2;

    // In-page offset where the page register lives on every page.
    localparam logic [PKG_LOW_W-1:0] PAGE_SLOT = 7'h7C;

    typedef enum logic {
        PH_COMMAND,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic                 is_write;
        logic [PKG_LOW_W-1:0] low;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [PKG_DATA_W-1:0] b);
        cmd_t c;
        c.is_write = b[PKG_DATA_W-1];
        c.low      = b[PKG_LOW_W-1:0];
        return c;
    endfunction

    function automatic logic hits_page(input logic [PKG_LOW_W-1:0] a);
        return a == PAGE_SLOT;
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
    import spi_paged_pkg::*;
#(
    parameter int unsigned STAGES = PKG_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_sync
);
    // One extra stage on sclk gives the previous value for edge detection.
    logic [STAGES:0]   sclk_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] mosi_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_pipe <= '0;
            cs_pipe   <= '1;
            mosi_pipe <= '0;
        end else begin
            sclk_pipe <= {sclk_pipe[STAGES-1:0], sclk_in};
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n_in};
            mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_in};
        end
    end

    always_comb begin
        cs_active = ~cs_pipe[STAGES-1];
        mosi_sync = mosi_pipe[STAGES-1];
        sclk_rise = sclk_pipe[STAGES-1] & ~sclk_pipe[STAGES] & cs_active;
        sclk_fall = ~sclk_pipe[STAGES-1] & sclk_pipe[STAGES] & cs_active;
    end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_paged_pkg::*;
#(
    parameter int unsigned DATA_W = PKG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rise,
    input  logic              fall,
    input  logic              mosi,
    input  logic [DATA_W-1:0] load_val,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                rx_sh <= {rx_sh[DATA_W-2:0], mosi};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (fall) begin
                // Falling edge at a byte boundary presents the next byte's MSB.
                if (bit_cnt == '0) tx_sh <= load_val;
                else               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        rx_byte = rx_sh;
        miso    = tx_sh[DATA_W-1];
    end

endmodule

// File: rtl/spi_paged_ctrl.sv
module spi_paged_ctrl
    import spi_paged_pkg::*;
#(
    parameter int unsigned ADDR_W = PKG_ADDR_W,
    parameter int unsigned LOW_W  = PKG_LOW_W,
    parameter int unsigned DATA_W = PKG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic [DATA_W-1:0] tx_buf
);
    localparam int unsigned PAGE_W = ADDR_W - LOW_W;

    phase_t            phase;
    logic              wr_mode;
    logic [LOW_W-1:0]  low;
    logic [PAGE_W-1:0] page;
    logic [1:0]        rd_pipe;

    cmd_t              cmd;
    logic              read_req;
    logic [LOW_W-1:0]  read_low;

    always_comb begin
        cmd      = decode_cmd(rx_byte);
        read_req = 1'b0;
        read_low = low + LOW_W'(1);
        if (active && byte_done) begin
            if (phase == PH_COMMAND) begin
                read_req = !cmd.is_write;
                read_low = cmd.low;
            end else begin
                read_req = !wr_mode;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_COMMAND;
            wr_mode   <= 1'b0;
            low       <= '0;
            page      <= '0;
            rd_pipe   <= '0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            tx_buf    <= '0;
        end else begin
            reg_we  <= 1'b0;
            reg_re  <= 1'b0;
            rd_pipe <= {rd_pipe[0], 1'b0};
            // Read data arrives the cycle after the strobe; latch it then.
            if (rd_pipe[1]) tx_buf <= reg_rdata;

            if (!active) begin
                phase   <= PH_COMMAND;
                wr_mode <= 1'b0;
                tx_buf  <= '0;
                rd_pipe <= '0;
            end else if (byte_done) begin
                if (phase == PH_COMMAND) begin
                    phase   <= PH_DATA;
                    wr_mode <= cmd.is_write;
                    low     <= cmd.low;
                    tx_buf  <= '0;
                end else begin
                    low <= low + LOW_W'(1);
                    if (wr_mode) begin
                        if (hits_page(low)) begin
                            page <= rx_byte[PAGE_W-1:0];
                        end else begin
                            reg_we    <= 1'b1;
                            reg_addr  <= {page, low};
                            reg_wdata <= rx_byte;
                        end
                    end
                end
                if (read_req) begin
                    if (hits_page(read_low)) begin
                        tx_buf <= DATA_W'(page);
                    end else begin
                        reg_re   <= 1'b1;
                        reg_addr <= {page, read_low};
                        rd_pipe  <= {rd_pipe[0], 1'b1};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_paged_regif.sv
module spi_paged_regif
    import spi_paged_pkg::*;
#(
    parameter int unsigned ADDR_W = PKG_ADDR_W,
    parameter int unsigned LOW_W  = PKG_LOW_W,
    parameter int unsigned DATA_W = PKG_DATA_W,
    parameter int unsigned SYNC   = PKG_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic              s_rise;
    logic              s_fall;
    logic              s_active;
    logic              s_mosi;
    logic              s_done;
    logic [DATA_W-1:0] s_rx;
    logic [DATA_W-1:0] s_tx_buf;

    spi_edge_sync #(.STAGES(SYNC)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (spi_sclk),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sclk_rise (s_rise),
        .sclk_fall (s_fall),
        .cs_active (s_active),
        .mosi_sync (s_mosi)
    );

    spi_byte_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .active    (s_active),
        .rise      (s_rise),
        .fall      (s_fall),
        .mosi      (s_mosi),
        .load_val  (s_tx_buf),
        .byte_done (s_done),
        .rx_byte   (s_rx),
        .miso      (spi_miso)
    );

    spi_paged_ctrl #(
        .ADDR_W (ADDR_W),
        .LOW_W  (LOW_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .active    (s_active),
        .byte_done (s_done),
        .rx_byte   (s_rx),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .tx_buf    (s_tx_buf)
    );

endmodule

// File: rtl/spi_paged_regif_checker.sv
module spi_paged_regif_checker
    import spi_paged_pkg::*;
#(
    parameter int unsigned ADDR_W = PKG_ADDR_W,
    parameter int unsigned LOW_W  = PKG_LOW_W
) (
    input logic              clk,
    input logic              rst,
    input logic              spi_cs_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic              reg_re
);
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, reg_re}))
        else $error("strobes overlap");

    p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we)
        else $error("write strobe longer than one cycle");

    p_re_single_r5: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re)
        else $error("read strobe longer than one cycle");

    p_page_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_we || reg_re) |-> !hits_page(reg_addr[LOW_W-1:0]))
        else $error("page offset reached register port");

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2)
         && $past(spi_cs_n, 3) && $past(spi_cs_n, 4)) |-> (!reg_we && !reg_re))
        else $error("strobe while deselected");

endmodule

bind spi_paged_regif spi_paged_regif_checker #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_cs_n (spi_cs_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_re   (reg_re)
);

// File: tb/test_spi_paged_regif.sv
module test_spi_paged_regif;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [10:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we;
    logic        reg_re;
    logic [7:0]  reg_rdata = 8'h00;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic [10:0] a;
        logic [7:0]  d;
    } wr_t;
    wr_t exp_q[$];

    logic [7:0] mem    [0:2047];
    logic [7:0] shadow [0:2047];
    logic [3:0] cur_page = 4'h0;

    always #10 clk = ~clk;

    spi_paged_regif i_spi_paged_regif (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    // Register file model: registered read, one cycle after the strobe.
    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (reg_re) reg_rdata <= mem[reg_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every write strobe must match the next expected item.
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected register write", int'(reg_addr), -1);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check(reg_addr == e.a, "R3 write address", int'(reg_addr), int'(e.a));
                check(reg_wdata == e.d, "R3 write data", int'(reg_wdata), int'(e.d));
            end
        end
        if (!rst && reg_re && reg_addr[6:0] == 7'h7C)
            check(1'b0, "R6 page offset read on port", int'(reg_addr), 0);
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Mode 0, MSB first (R8).
    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = tx[7 - i];
            wait_clk(HALF);
            rx = {rx[6:0], spi_miso};
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic frame_begin();
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_end();
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic do_write(input logic [6:0] low, input int n, input logic [7:0] seed);
        logic [7:0] rx;
        frame_begin();
        xfer({1'b1, low}, 8, rx);
        check(rx == 8'h00, "R5 MISO zero in write command", rx, 0);
        for (int i = 0; i < n; i++) begin
            logic [6:0] a;
            logic [7:0] d;
            a = low + 7'(i);
            d = seed + 8'(i);
            if (a == 7'h7C) begin
                cur_page = d[3:0];
            end else begin
                exp_q.push_back('{a: {cur_page, a}, d: d});
                shadow[{cur_page, a}] = d;
            end
            xfer(d, 8, rx);
            check(rx == 8'h00, "R5 MISO zero in write data", rx, 0);
        end
        frame_end();
        check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    endtask

    task automatic do_read(input logic [6:0] low, input int n, input string req);
        logic [7:0] rx;
        frame_begin();
        xfer({1'b0, low}, 8, rx);
        check(rx == 8'h00, "R5 MISO zero in read command", rx, 0);
        for (int i = 0; i < n; i++) begin
            logic [6:0] a;
            logic [7:0] e;
            a = low + 7'(i);
            e = (a == 7'h7C) ? {4'h0, cur_page} : shadow[{cur_page, a}];
            xfer(8'h00, 8, rx);
            check(rx == e, req, rx, e);
        end
        frame_end();
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem[i]    = 8'(i * 7 + 3) ^ 8'(i >> 8);
            shadow[i] = 8'(i * 7 + 3) ^ 8'(i >> 8);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired (all requirements)");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1: reset state at the ports
        check(spi_miso == 1'b0, "R1 MISO low after reset", spi_miso, 0);
        check(!reg_we && !reg_re, "R1 strobes low after reset", {reg_we, reg_re}, 0);
        do_read(7'h7C, 1, "R1 R6 page reads zero after reset");

        // R2 R3 R8: single write then read back (MSB-first pattern)
        do_write(7'h10, 1, 8'h81);
        do_read(7'h10, 1, "R5 R8 single read back");

        // R4: burst wraps from 0x7E to 0x01 within page 0
        do_write(7'h7E, 4, 8'hC3);
        do_read(7'h7F, 3, "R4 R5 burst read across wrap");

        // R6: select page 5 through command 0xFC, confirm, use it
        do_write(7'h7C, 1, 8'hF5);
        do_read(7'h7C, 1, "R6 page readback five");
        do_write(7'h20, 2, 8'h3A);
        do_read(7'h1F, 4, "R2 R5 read in page five");

        // R6 R4: page change in the middle of a burst moves later writes
        do_write(7'h7B, 3, 8'h45);
        check(cur_page == 4'h6, "R6 bench page tracking", cur_page, 6);
        do_read(7'h7A, 4, "R5 R6 read across page slot");

        // R7: abort a data byte midway; no write, framing restarts
        frame_begin();
        xfer(8'hB0, 8, rx);
        xfer(8'hEE, 4, rx);
        spi_cs_n = 1'b1;
        spi_sclk = 1'b0;
        wait_clk(4 * HALF);
        do_read(7'h30, 1, "R7 aborted byte left register unchanged");
        do_write(7'h30, 1, 8'h5C);
        do_read(7'h30, 1, "R7 command framing after abort");

        // R9 / R1: idle port after all traffic
        wait_clk(10);
        check(!reg_we && !reg_re, "R9 no strobes while idle", {reg_we, reg_re}, 0);
        check(spi_miso == 1'b0, "R1 MISO low while idle", spi_miso, 0);
        check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule